// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This unit turns the operand fields of a memory instruction into the byte address that the memory stage will use. Each request carries a base register value, an index register value, a two-bit scale selector, a raw offset together with a code saying how many of its low bits are significant, and a three-bit addressing-mode code. The unit sign-extends the offset, scales the index by a power of two, and forms the address the chosen mode calls for. All arithmetic wraps modulo 2^32.

Two of the modes also change the base register: post-increment addresses through the base and then steps it by one, and pre-update adds the offset to the base, uses that sum as the address and writes it back as the new base. For these the unit presents the new base value and a write-back strobe that the register file can act on directly. Results are registered: a request accepted with `req_valid` high appears on the outputs one clock later with `rsp_valid` high. Between requests the result outputs keep their last values.

Top module: `eff_addr_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `rsp_valid`, `base_wr_en`, `eff_addr` and `next_base` all become zero on that edge.
- R2: `rsp_valid` after a rising edge equals `req_valid` sampled at that edge, so each result appears exactly one cycle after its request.
- R3: Mode code 0 (absolute) gives `eff_addr` = the sign-extended offset.
- R4: Mode code 1 (register indirect) and the unused code 7 both give `eff_addr` = `base_val` unchanged.
- R5: Mode code 2 (indexed) gives `eff_addr` = `base_val` + `index_val`.
- R6: Mode code 3 (displacement) gives `eff_addr` = `base_val` + sign-extended offset.
- R7: Mode code 4 (scaled index) gives `eff_addr` = `base_val` + (`index_val` shifted left by `scale_sel` bits, a factor of 1, 2, 4 or 8) + sign-extended offset.
- R8: `ofs_width` code 0 takes `ofs_raw[7:0]` and code 1 takes `ofs_raw[15:0]`, each sign-extended to 32 bits with the upper raw bits ignored; codes 2 and 3 take all 32 bits.
- R9: Mode code 5 (post-increment) gives `eff_addr` = `base_val` and `next_base` = `base_val` + 1.
- R10: Mode code 6 (pre-update) gives `eff_addr` and `next_base` both equal to `base_val` + sign-extended offset.
- R11: `base_wr_en` is high one cycle after an accepted request in mode 5 or 6 and low after every other cycle; in modes that do not update, `next_base` = `base_val`.
- R12: Every sum wraps modulo 2^32 with no carry kept.
- R13: After a cycle with `req_valid` low, `eff_addr` and `next_base` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request fields are valid this cycle |
| addr_mode | input | 3 | Addressing-mode code (0..6, 7 acts as register indirect) |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| scale_sel | input | 2 | Index left-shift amount, 0 to 3 |
| ofs_raw | input | 32 | Raw offset field |
| ofs_width | input | 2 | Significant offset width: 0 = 8, 1 = 16, 2/3 = 32 bits |
| rsp_valid | output | 1 | Result outputs belong to the request of the previous cycle |
| eff_addr | output | 32 | Effective address |
| next_base | output | 32 | Value to write back to the base register |
| base_wr_en | output | 1 | Write-back strobe for `next_base` |

## Verification
Every result of this unit (address, new base, strobe and valid) is due on the first rising edge after the request, so the bench drives a request just after a falling edge and compares all outputs at the next falling edge, half a period after they were registered. Cycles with `req_valid` low are checked at the same point against the values the previous request left behind, and the reset check samples after an edge taken while reset is low. Random requests over all modes, widths and scales are mixed with directed cases for sign extension, wrap-around, the largest scale and the unused mode code.

// File: rtl/eau_pkg.sv
// Shared definitions for the effective address generator.
// Assumes: mode and width codes are decoded only through these types.
package eau_pkg;

    localparam int ADDR_W  = 32;
    localparam int SCALE_W = 2;

    // Addressing-mode codes; code 7 is unused and treated as register indirect
    typedef enum logic [2:0] {
        MODE_ABS     = 3'd0,
        MODE_REGIND  = 3'd1,
        MODE_INDEXED = 3'd2,
        MODE_DISP    = 3'd3,
        MODE_SCALED  = 3'd4,
        MODE_POSTINC = 3'd5,
        MODE_PREUPD  = 3'd6,
        MODE_UNUSED  = 3'd7
    } amode_e;

    // Significant width of the raw offset field
    typedef enum logic [1:0] {
        OFW_8   = 2'd0,
        OFW_16  = 2'd1,
        OFW_32  = 2'd2,
        OFW_32B = 2'd3
    } ofs_width_e;

endpackage

// File: rtl/eau_ofs_extend.sv
// Offset sign extender.
// Picks the significant low bits of the raw offset according to the width
// code and sign-extends them to the address width.
// Assumes: ADDR_W is at least WIDE_B; upper raw bits are don't-care.
module eau_ofs_extend
    import eau_pkg::*;
#(
    parameter int ADDR_W = eau_pkg::ADDR_W,
    parameter int WIDE_A = 8,
    parameter int WIDE_B = 16
) (
    input  logic [ADDR_W-1:0] ofs_raw,
    input  logic [1:0]        width_code,
    output logic [ADDR_W-1:0] ofs_ext
);

    localparam int PAD_A = ADDR_W - WIDE_A;
    localparam int PAD_B = ADDR_W - WIDE_B;

    // Select and sign-extend the offset field
    always_comb begin
        case (ofs_width_e'(width_code))
            OFW_8:   ofs_ext = {{PAD_A{ofs_raw[WIDE_A-1]}}, ofs_raw[WIDE_A-1:0]};
            OFW_16:  ofs_ext = {{PAD_B{ofs_raw[WIDE_B-1]}}, ofs_raw[WIDE_B-1:0]};
            default: ofs_ext = ofs_raw;
        endcase
    end

    // Narrow offsets must leave the upper bits as copies of one sign bit
    always_comb begin
        if (ofs_width_e'(width_code) == OFW_8) begin
            AST_NARROW_SIGN: assert (ofs_ext[ADDR_W-1:WIDE_A-1] == '0 ||
                                     ofs_ext[ADDR_W-1:WIDE_A-1] == '1); // R8
        end
    end

endmodule

// File: rtl/eau_idx_scale.sv
// Index scaler.
// Shifts the index left by 0 to 2^SCALE_W-1 bits through a logarithmic
// shifter, one stage per bit of the shift selector.
// Assumes: bits shifted out of the top are discarded (modulo arithmetic).
module eau_idx_scale #(
    parameter int ADDR_W  = eau_pkg::ADDR_W,
    parameter int SCALE_W = eau_pkg::SCALE_W
) (
    input  logic [ADDR_W-1:0]  index_in,
    input  logic [SCALE_W-1:0] shift_sel,
    output logic [ADDR_W-1:0]  index_scaled
);

    logic [ADDR_W-1:0] stage [SCALE_W+1];

    assign stage[0] = index_in;

    genvar g;
    generate
        for (g = 0; g < SCALE_W; g++) begin : g_stage
            // Stage g shifts by 2^g when its selector bit is set
            always_comb begin
                stage[g+1] = shift_sel[g] ? (stage[g] << (1 << g)) : stage[g];
            end
        end
    endgenerate

    assign index_scaled = stage[SCALE_W];

    // A shift of k must leave the k low bits clear
    always_comb begin
        AST_SCALE_LOW_ZERO: assert ((index_scaled &
            ((ADDR_W'(1) << shift_sel) - ADDR_W'(1))) == '0); // R7
    end

endmodule

// File: rtl/eau_addr_core.sv
// Address formation core.
// Decodes the mode and forms the address, the updated base and the raw
// update request from already-extended offset and already-scaled index.
// Assumes: inputs are stable for the cycle; all sums wrap at ADDR_W bits.
module eau_addr_core
    import eau_pkg::*;
#(
    parameter int ADDR_W = eau_pkg::ADDR_W
) (
    input  logic [2:0]        mode_code,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    input  logic [ADDR_W-1:0] index_scaled,
    input  logic [ADDR_W-1:0] ofs_ext,
    output logic [ADDR_W-1:0] addr_out,
    output logic [ADDR_W-1:0] base_out,
    output logic              base_upd
);

    logic [ADDR_W-1:0] sum_disp;
    logic [ADDR_W-1:0] sum_idx;
    logic [ADDR_W-1:0] sum_scaled;
    logic [ADDR_W-1:0] sum_inc;

    // Candidate sums, each truncated to the address width
    always_comb begin
        sum_disp   = base_val + ofs_ext;
        sum_idx    = base_val + index_val;
        sum_scaled = base_val + index_scaled + ofs_ext;
        sum_inc    = base_val + ADDR_W'(1);
    end

    // Mode decode: choose address, new base and update request
    always_comb begin
        addr_out = base_val;
        base_out = base_val;
        base_upd = 1'b0;
        case (amode_e'(mode_code))
            MODE_ABS:     addr_out = ofs_ext;
            MODE_REGIND:  addr_out = base_val;
            MODE_INDEXED: addr_out = sum_idx;
            MODE_DISP:    addr_out = sum_disp;
            MODE_SCALED:  addr_out = sum_scaled;
            MODE_POSTINC: begin
                addr_out = base_val;
                base_out = sum_inc;
                base_upd = 1'b1;
            end
            MODE_PREUPD: begin
                addr_out = sum_disp;
                base_out = sum_disp;
                base_upd = 1'b1;
            end
            default:      addr_out = base_val;
        endcase
    end

    // Without an update request the base must pass through unchanged
    always_comb begin
        if (!base_upd) begin
            AST_BASE_PASS: assert (base_out == base_val); // R11
        end
    end

endmodule

// File: rtl/eff_addr_gen.sv
// Multi-mode effective address generator, top level.
// Combinational offset extension, index scaling and address formation,
// followed by one register stage that presents the result with a valid.
// Assumes: synchronous active-low reset; result registers load only on
// accepted requests and hold otherwise.
module eff_addr_gen
    import eau_pkg::*;
#(
    parameter int ADDR_W  = eau_pkg::ADDR_W,
    parameter int SCALE_W = eau_pkg::SCALE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [2:0]         addr_mode,
    input  logic [ADDR_W-1:0]  base_val,
    input  logic [ADDR_W-1:0]  index_val,
    input  logic [SCALE_W-1:0] scale_sel,
    input  logic [ADDR_W-1:0]  ofs_raw,
    input  logic [1:0]         ofs_width,
    output logic               rsp_valid,
    output logic [ADDR_W-1:0]  eff_addr,
    output logic [ADDR_W-1:0]  next_base,
    output logic               base_wr_en
);

    logic [ADDR_W-1:0] ofs_ext;
    logic [ADDR_W-1:0] idx_scaled;
    logic [ADDR_W-1:0] addr_c;
    logic [ADDR_W-1:0] base_c;
    logic              upd_c;

    eau_ofs_extend #(.ADDR_W(ADDR_W)) ofs_ext_i (
        .ofs_raw    (ofs_raw),
        .width_code (ofs_width),
        .ofs_ext    (ofs_ext)
    );

    eau_idx_scale #(.ADDR_W(ADDR_W), .SCALE_W(SCALE_W)) idx_scale_i (
        .index_in     (index_val),
        .shift_sel    (scale_sel),
        .index_scaled (idx_scaled)
    );

    eau_addr_core #(.ADDR_W(ADDR_W)) addr_core_i (
        .mode_code    (addr_mode),
        .base_val     (base_val),
        .index_val    (index_val),
        .index_scaled (idx_scaled),
        .ofs_ext      (ofs_ext),
        .addr_out     (addr_c),
        .base_out     (base_c),
        .base_upd     (upd_c)
    );

    // Valid and write-back strobe pipeline register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            base_wr_en <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            base_wr_en <= req_valid & upd_c;
        end
    end

    // Result register, loaded only on an accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_addr  <= '0;
            next_base <= '0;
        end else if (req_valid) begin
            eff_addr  <= addr_c;
            next_base <= base_c;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2
    AST_WR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr_en |-> rsp_valid); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(eff_addr) && $stable(next_base))); // R13
    AST_PREUPD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && addr_mode == 3'd6) |=> (eff_addr == next_base)); // R10
    AST_REGIND_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && addr_mode == 3'd1) |=> (eff_addr == $past(base_val))); // R4
    AST_POSTINC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && addr_mode == 3'd5) |=> (eff_addr == $past(base_val))); // R9

endmodule

// File: tb/eff_addr_gen_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench for the effective address generator: directed
// corner cases followed by seeded random requests, checked against a
// model written from the requirements.
module eff_addr_gen_tb_top;

    localparam int WATCHDOG_CYC = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  addr_mode = '0;
    logic [31:0] base_val = '0;
    logic [31:0] index_val = '0;
    logic [1:0]  scale_sel = '0;
    logic [31:0] ofs_raw = '0;
    logic [1:0]  ofs_width = '0;
    logic        rsp_valid;
    logic [31:0] eff_addr;
    logic [31:0] next_base;
    logic        base_wr_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [31:0] hold_addr = '0;
    logic [31:0] hold_base = '0;

    always #2 clk = ~clk;

    eff_addr_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .addr_mode  (addr_mode),
        .base_val   (base_val),
        .index_val  (index_val),
        .scale_sel  (scale_sel),
        .ofs_raw    (ofs_raw),
        .ofs_width  (ofs_width),
        .rsp_valid  (rsp_valid),
        .eff_addr   (eff_addr),
        .next_base  (next_base),
        .base_wr_en (base_wr_en)
    );

    // Model of offset selection per R8
    function automatic logic [31:0] m_ofs(input logic [31:0] raw, input logic [1:0] w);
        if (w == 2'd0) return {{24{raw[7]}}, raw[7:0]};
        if (w == 2'd1) return {{16{raw[15]}}, raw[15:0]};
        return raw;
    endfunction

    // Model of the address per R3..R7, R9, R10, R12
    function automatic logic [31:0] m_addr(input logic [2:0] m, input logic [31:0] b,
        input logic [31:0] x, input logic [1:0] s, input logic [31:0] raw, input logic [1:0] w);
        logic [31:0] o;
        o = m_ofs(raw, w);
        case (m)
            3'd0: return o;
            3'd2: return b + x;
            3'd3: return b + o;
            3'd4: return b + x * (32'd1 << s) + o;
            3'd6: return b + o;
            default: return b;
        endcase
    endfunction

    // Model of the new base per R9..R11
    function automatic logic [31:0] m_base(input logic [2:0] m, input logic [31:0] b,
        input logic [31:0] raw, input logic [1:0] w);
        if (m == 3'd5) return b + 32'd1;
        if (m == 3'd6) return b + m_ofs(raw, w);
        return b;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply one request (or idle cycle) after a falling edge and check
    // all outputs at the next falling edge.
    task automatic step(input string tag, input bit v, input logic [2:0] m,
        input logic [31:0] b, input logic [31:0] x, input logic [1:0] s,
        input logic [31:0] raw, input logic [1:0] w);
        logic [31:0] ea, eb;
        bit          ew;
        req_valid = v; addr_mode = m; base_val = b; index_val = x;
        scale_sel = s; ofs_raw = raw; ofs_width = w;
        if (v) begin
            ea = m_addr(m, b, x, s, raw, w);
            eb = m_base(m, b, raw, w);
            ew = (m == 3'd5 || m == 3'd6);
        end else begin
            ea = hold_addr;
            eb = hold_base;
            ew = 1'b0;
        end
        @(negedge clk);
        chk({tag, " valid (R2)"}, 32'(rsp_valid), 32'(v));
        chk({tag, " addr"}, eff_addr, ea);
        chk({tag, " base"}, next_base, eb);
        chk({tag, " strobe (R11)"}, 32'(base_wr_en), 32'(ew));
        hold_addr = ea;
        hold_base = eb;
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        // R1: reset state, with a live request presented during reset
        @(negedge clk);
        req_valid = 1'b1; addr_mode = 3'd6; base_val = 32'h1234_5678; ofs_raw = 32'h10;
        @(negedge clk);
        @(negedge clk);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 eff_addr", eff_addr, 32'd0);
        chk("R1 next_base", next_base, 32'd0);
        chk("R1 base_wr_en", 32'(base_wr_en), 32'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corner cases
        step("R3 absolute neg8", 1, 3'd0, 32'hDEAD_BEEF, 32'h0, 2'd0, 32'hFFFF_FF80, 2'd0);
        step("R3 absolute 32", 1, 3'd0, 32'h1, 32'h0, 2'd0, 32'h8000_0004, 2'd2);
        step("R4 reg indirect", 1, 3'd1, 32'hCAFE_0010, 32'h55, 2'd3, 32'h7F, 2'd0);
        step("R4 unused code 7", 1, 3'd7, 32'h0BAD_F00D, 32'h9, 2'd1, 32'h44, 2'd1);
        step("R13 idle hold", 0, 3'd3, 32'hFFFF_0000, 32'h1, 2'd1, 32'h1, 2'd2);
        step("R5 indexed", 1, 3'd2, 32'h0000_1000, 32'h0000_0234, 2'd3, 32'h0, 2'd0);
        step("R6 disp neg16", 1, 3'd3, 32'h0000_1000, 32'h0, 2'd0, 32'h1234_FFF0, 2'd1);
        step("R8 upper bits ignored 8", 1, 3'd3, 32'h0000_0100, 32'h0, 2'd0, 32'hABCD_EF7F, 2'd0);
        step("R8 width code 3", 1, 3'd3, 32'h0000_0100, 32'h0, 2'd0, 32'h8000_0000, 2'd3);
        step("R7 scale x8", 1, 3'd4, 32'h0000_0100, 32'h0000_0010, 2'd3, 32'h4, 2'd0);
        step("R7 scale x1", 1, 3'd4, 32'h0000_0100, 32'h0000_0010, 2'd0, 32'hFC, 2'd0);
        step("R12 scaled wrap", 1, 3'd4, 32'hFFFF_FFF0, 32'hF000_0001, 2'd3, 32'h0000_7FFF, 2'd1);
        step("R9 post-increment", 1, 3'd5, 32'h0000_00FF, 32'h3, 2'd2, 32'h80, 2'd0);
        step("R12 post-increment wrap", 1, 3'd5, 32'hFFFF_FFFF, 32'h0, 2'd0, 32'h0, 2'd0);
        step("R10 pre-update neg", 1, 3'd6, 32'h0000_2000, 32'h0, 2'd0, 32'h0000_0080, 2'd0);
        step("R13 idle after update", 0, 3'd5, 32'h1, 32'h2, 2'd0, 32'h3, 2'd0);
        step("R12 pre-update wrap", 1, 3'd6, 32'hFFFF_FFF8, 32'h0, 2'd0, 32'h0000_0010, 2'd2);
        step("R11 no strobe in disp", 1, 3'd3, 32'h40, 32'h0, 2'd0, 32'h1, 2'd0);

        // Random requests over all modes, widths and scales
        for (int i = 0; i < 3000; i++) begin
            bit          v;
            logic [31:0] b, x, raw;
            v   = ($urandom % 4) != 0;
            b   = $urandom;
            x   = $urandom;
            raw = $urandom;
            step("random R3-R13 mix", v, 3'($urandom % 8), b, x, 2'($urandom % 4),
                 raw, 2'($urandom % 4));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: an expired run counts as one failed check
    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule